// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the internal address for one port of a synchronous multi-port memory during burst accesses. An external address can be captured into the counter. The counter can then be stepped by one on each clock edge where the increment control is low. A separate mask register sets the counting range. Bit positions covered by the mask take part in counting. Bit positions outside it keep the value they had when the counter was loaded. Once the counted bits are all ones, the next step returns them to zero.

On every such wrap, the active-low interrupt output pulses low for one clock and then releases by itself. This lets the port's controller know that a circular buffer region has been traversed. All controls are active low and sampled on the rising clock edge. The block has two reset levels. A global synchronous reset clears everything. Two per-function resets clear only the counter or only the mask.

Top module: `burst_addr_ctr`

## Requirements
- R1: With counter reset high and load low at a rising edge, the internal address becomes the external address.
- R2: An increment (increment low, load and counter reset high) adds one within the bit positions whose mask bit is 1; bit positions whose mask bit is 0 keep their value.
- R3: An increment taken while every masked bit of the counter is 1 sets those bits to 0 and leaves the unmasked bits unchanged (mask 007Fh: xx7Eh, xx7Fh, xx00h).
- R4: The interrupt output goes low at the same edge where a wrapping increment updates the address, stays low for exactly that one cycle unless the next cycle wraps again, and is otherwise high.
- R5: A mask load (mask-load low, mask reset high) stores a contiguous mask: mask bit i is 1 exactly when external address bits 0 through i are all 1 (ext 00F3h gives mask 0003h).
- R6: Counter reset low clears the internal address to 0000h and overrides load and increment in the same cycle.
- R7: Mask reset low sets the mask to all ones (full range) and overrides a mask load in the same cycle.
- R8: When load and increment are both low, the load wins and no increment is applied.
- R9: With no control low, the internal address holds and the interrupt stays high.
- R10: Global reset low at a rising edge gives address 0000h, mask all ones and interrupt high.
- R11: An increment uses the mask held before the edge, even when a mask load happens at the same edge.
- R12: With an all-zero mask, an increment leaves the address unchanged and counts as a wrap, so the interrupt goes low on every such increment.
- R13: The interrupt output is always driven to a known 0 or 1 once out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Global synchronous reset, active low |
| ext_addr | input | ADDR_W | External address, source for counter and mask loads |
| ld_n | input | 1 | Counter load, active low |
| inc_n | input | 1 | Counter increment, active low |
| mld_n | input | 1 | Mask load, active low |
| crst_n | input | 1 | Counter clear, active low |
| mrst_n | input | 1 | Mask set to full range, active low |
| int_addr | output | ADDR_W | Current internal address |
| cint_n | output | 1 | Wrap interrupt, active low, one cycle |

## Verification
The bench instantiates the block at its default 16-bit width. This keeps the full-range wrap from FFFFh to 0000h and the top mask bit inside the tested space. Random mask loads favour short runs of ones, zero to six bits, with random garbage above the first zero. Under those masks, wraps and back-to-back interrupts occur within a handful of increments. Collisions such as load with increment, clear with load and mask load with increment arise naturally in that stream.

// File: rtl/bac_pkg.sv
// Shared definitions for the masked burst address counter.
// Assumes: controls are already resolved to a single operation per cycle.
package bac_pkg;

    // Operation applied to the counter at the next rising edge
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_INC  = 2'd2,
        CNT_CLR  = 2'd3
    } cnt_op_e;

    // Resolve active-low controls by priority: clear, then load, then increment
    function automatic cnt_op_e resolve_op(input logic crst_n,
                                           input logic ld_n,
                                           input logic inc_n);
        if (!crst_n)     return CNT_CLR;
        else if (!ld_n)  return CNT_LOAD;
        else if (!inc_n) return CNT_INC;
        else             return CNT_HOLD;
    endfunction

endpackage

// File: rtl/bac_mask_reg.sv
// Mask register. Stores a contiguous run of ones that starts at bit 0.
// The stored run is derived from the external value: bit i is set only
// when bits 0..i of the loaded value are all set.
// Assumes: synchronous active-low resets; mask reset wins over mask load.
module bac_mask_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mrst_n,
    input  logic         mld_n,
    input  logic [W-1:0] ext_addr,
    output logic [W-1:0] mask
);

    logic [W-1:0] run;

    // Prefix AND: keeps the low run of ones only
    assign run[0] = ext_addr[0];
    generate
        for (genvar i = 1; i < W; i++) begin : g_run
            assign run[i] = run[i-1] & ext_addr[i];
        end
    endgenerate

    // Mask storage with reset-to-full-range
    always_ff @(posedge clk) begin
        if (!rst_n || !mrst_n) begin
            mask <= '1;
        end else if (!mld_n) begin
            mask <= run;
        end
    end

endmodule

// File: rtl/bac_counter.sv
// Address counter. Masked bits count, unmasked bits hold.
// Flags a wrap when an increment is taken with all masked bits set.
// Assumes: mask is a contiguous low run of ones.
module bac_counter
    import bac_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_op_e      op,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] ext_addr,
    output logic [W-1:0] cnt,
    output logic         wrap_now
);

    logic [W-1:0] plus_one;
    logic [W-1:0] stepped;
    logic         at_top;

    // Step only the masked field; carry into held bits is discarded
    always_comb begin
        plus_one = cnt + W'(1);
        stepped  = (cnt & ~mask) | (plus_one & mask);
        at_top   = ((cnt & mask) == mask);
        wrap_now = (op == CNT_INC) && at_top;
    end

    // Counter register update by resolved operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (op)
                CNT_CLR:  cnt <= '0;
                CNT_LOAD: cnt <= ext_addr;
                CNT_INC:  cnt <= stepped;
                default:  cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/bac_irq.sv
// Wrap interrupt. Registers the wrap flag into an active-low pulse that
// lines up with the address update and releases on its own.
// Assumes: output is always driven (never released to high impedance).
module bac_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_now,
    output logic cint_n
);

    // One-cycle low pulse per wrapping edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cint_n <= 1'b1;
        end else begin
            cint_n <= ~wrap_now;
        end
    end

endmodule

// File: rtl/burst_addr_ctr.sv
// Masked burst address counter, top level for one memory port.
// Resolves the control priority, then drives the mask register, the
// counter and the wrap interrupt.
// Assumes: all inputs are synchronous to clk.
module burst_addr_ctr
    import bac_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ld_n,
    input  logic              inc_n,
    input  logic              mld_n,
    input  logic              crst_n,
    input  logic              mrst_n,
    output logic [ADDR_W-1:0] int_addr,
    output logic              cint_n
);

    cnt_op_e           op;
    logic [ADDR_W-1:0] mask_q;
    logic              wrap_now;

    // Control priority: clear over load over increment
    always_comb begin
        op = resolve_op(crst_n, ld_n, inc_n);
    end

    bac_mask_reg #(.W(ADDR_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .mrst_n   (mrst_n),
        .mld_n    (mld_n),
        .ext_addr (ext_addr),
        .mask     (mask_q)
    );

    bac_counter #(.W(ADDR_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .mask     (mask_q),
        .ext_addr (ext_addr),
        .cnt      (int_addr),
        .wrap_now (wrap_now)
    );

    bac_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_now (wrap_now),
        .cint_n   (cint_n)
    );

endmodule

// File: rtl/bac_chk.sv
// Checker for the masked burst address counter, bound to the top.
// Assumes: mask is observed from the top-level mask register signal.
module bac_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         crst_n,
    input logic         ld_n,
    input logic         inc_n,
    input logic [W-1:0] ext_addr,
    input logic [W-1:0] int_addr,
    input logic         cint_n,
    input logic [W-1:0] mask
);

    // R1
    load_takes_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crst_n && !ld_n) |=> (int_addr == $past(ext_addr)));

    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!crst_n) |=> (int_addr == '0));

    // R2
    held_bits_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crst_n && ld_n && !inc_n) |=>
            ((int_addr & ~$past(mask)) == ($past(int_addr) & ~$past(mask))));

    // R4
    irq_only_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cint_n) |-> $past(crst_n && ld_n && !inc_n && ((int_addr & mask) == mask)));

    // R4
    irq_on_every_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crst_n && ld_n && !inc_n && ((int_addr & mask) == mask)) |=> !cint_n);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crst_n && ld_n && inc_n) |=> ($stable(int_addr) && cint_n));

    // R5
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & W'(mask + W'(1))) == '0));

    // R13
    irq_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(cint_n));

endmodule

bind burst_addr_ctr bac_chk #(.W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .crst_n   (crst_n),
    .ld_n     (ld_n),
    .inc_n    (inc_n),
    .ext_addr (ext_addr),
    .int_addr (int_addr),
    .cint_n   (cint_n),
    .mask     (mask_q)
);

// File: tb/sim_burst_addr_ctr.sv
`timescale 1ns/1ps
module sim_burst_addr_ctr;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ext_addr = '0;
    logic         ld_n = 1'b1, inc_n = 1'b1, mld_n = 1'b1, crst_n = 1'b1, mrst_n = 1'b1;
    logic [W-1:0] int_addr;
    logic         cint_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] m_cnt;
    logic [W-1:0] m_mask;
    logic         m_cint;

    always #2.5 clk = ~clk;

    burst_addr_ctr #(.ADDR_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .ld_n(ld_n),
        .inc_n(inc_n), .mld_n(mld_n), .crst_n(crst_n), .mrst_n(mrst_n),
        .int_addr(int_addr), .cint_n(cint_n)
    );

    // Contiguous run of ones from bit 0 (R5 rule)
    function automatic logic [W-1:0] contig(input logic [W-1:0] v);
        logic [W-1:0] r = '0;
        logic run = 1'b1;
        for (int i = 0; i < W; i++) begin
            run  = run & v[i];
            r[i] = run;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] step_val(input logic [W-1:0] c, input logic [W-1:0] m);
        logic [W-1:0] p = c + W'(1);
        return (c & ~m) | (p & m);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] exp_a, input logic exp_i);
        n_chk++;
        if (int_addr !== exp_a || cint_n !== exp_i) begin
            n_bad++;
            $display("FAIL %s: addr=%h cint_n=%b expected addr=%h cint_n=%b",
                     tag, int_addr, cint_n, exp_a, exp_i);
        end
    endtask

    // Drive one cycle, update model, compare after the edge
    task automatic step(input logic ld, input logic inc, input logic mld,
                        input logic crst, input logic mrst,
                        input logic [W-1:0] ext, input string tag_in);
        logic wrap;
        string tag;
        @(negedge clk);
        ld_n = ld; inc_n = inc; mld_n = mld; crst_n = crst; mrst_n = mrst; ext_addr = ext;
        wrap = crst && ld && !inc && ((m_cnt & m_mask) == m_mask);
        if (!crst)     tag = "R6";
        else if (!ld)  tag = inc ? "R1" : "R8";
        else if (!inc) tag = wrap ? "R3" : "R2";
        else           tag = "R9";
        if (tag_in != "") tag = tag_in;
        @(posedge clk);
        if (!crst)     m_cnt = '0;
        else if (!ld)  m_cnt = ext;
        else if (!inc) m_cnt = step_val(m_cnt, m_mask);
        if (!mrst)     m_mask = '1;
        else if (!mld) m_mask = contig(ext);
        m_cint = ~wrap;
        #1;
        check(tag, m_cnt, m_cint);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_cnt = '0; m_mask = '1; m_cint = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 check("R10", 16'h0000, 1'b1);
        // R10 mask full: FFFF wraps after loading FFFE? verified below under R7

        // R3 R4: mask 007F, count through the top
        step(1, 1, 0, 1, 1, 16'h007F, "R5");
        step(0, 1, 1, 1, 1, 16'h127D, "R1");
        step(1, 0, 1, 1, 1, 16'h0000, "R2");
        check("R2", 16'h127E, 1'b1);
        step(1, 0, 1, 1, 1, 16'h0000, "R2");
        step(1, 0, 1, 1, 1, 16'h0000, "R3");
        check("R3", 16'h1200, 1'b0);
        step(1, 0, 1, 1, 1, 16'h0000, "R4");
        check("R4", 16'h1201, 1'b1);
        // R8 load beats increment
        step(0, 0, 1, 1, 1, 16'hABCD, "R8");
        check("R8", 16'hABCD, 1'b1);
        // R6 clear beats load and increment
        step(0, 0, 1, 0, 1, 16'h5555, "R6");
        check("R6", 16'h0000, 1'b1);
        // R5 non-contiguous value keeps only low run (00F3 -> 0003)
        step(1, 1, 0, 1, 1, 16'h00F3, "R5");
        step(0, 1, 1, 1, 1, 16'h00F2, "R5");
        step(1, 0, 1, 1, 1, 16'h0000, "R5");
        step(1, 0, 1, 1, 1, 16'h0000, "R5");
        check("R5", 16'h00F0, 1'b0);
        // R7 mask reset beats mask load, full range wrap
        step(1, 1, 0, 1, 0, 16'h0001, "R7");
        step(0, 1, 1, 1, 1, 16'hFFFE, "R7");
        step(1, 0, 1, 1, 1, 16'h0000, "R7");
        step(1, 0, 1, 1, 1, 16'h0000, "R7");
        check("R7", 16'h0000, 1'b0);
        // R11 increment uses old mask during same-edge mask load
        step(1, 0, 0, 1, 1, 16'h0001, "R11");
        check("R11", 16'h0001, 1'b1);
        step(1, 0, 1, 1, 1, 16'h0000, "R11");
        check("R11", 16'h0000, 1'b0);
        // R12 zero mask: address frozen, interrupt every increment
        step(1, 1, 0, 1, 1, 16'hFFFE, "R12");
        step(0, 1, 1, 1, 1, 16'h1234, "R12");
        step(1, 0, 1, 1, 1, 16'h0000, "R12");
        check("R12", 16'h1234, 1'b0);
        step(1, 0, 1, 1, 1, 16'h0000, "R12");
        check("R12", 16'h1234, 1'b0);
        // R9 idle
        step(1, 1, 1, 1, 1, 16'hFFFF, "R9");
        check("R9", 16'h1234, 1'b1);

        // Random mix; R13 known interrupt checked by 4-state compare
        void'($urandom(32'd2024));
        for (int k = 0; k < 4000; k++) begin
            logic [W-1:0] ext;
            int r;
            logic ld, inc, mld, crst, mrst;
            ext = W'($urandom);
            r   = $urandom_range(0, 99);
            crst = (r >= 3);
            ld   = !($urandom_range(0, 99) < 10);
            inc  = !($urandom_range(0, 99) < 70);
            mld  = !($urandom_range(0, 99) < 6);
            mrst = !($urandom_range(0, 99) < 2);
            if (!mld) begin
                int bits = $urandom_range(0, 6);
                ext = (ext & ~(W'(1) << bits)) & ~((W'(1) << bits) - W'(1));
                ext = ext | ((W'(1) << bits) - W'(1));
            end
            step(ld, inc, mld, crst, mrst, ext, "");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule